// File: doc/BRIEF.md
# Instruction Queue with Branch Folding

This block sits between instruction fetch and the execution units. Each cycle it can accept up to two fetched words, each carrying its fetch address and a branch flag produced by predecode. Words are held in a small age-ordered queue. Non-branch words leave strictly in order from the head through a valid/ready dispatch port. Branch words can be pulled out early, from any occupied slot, through a separate branch port. This lets a branch resolve while older non-branch work is still waiting, which is the point of folding.

When a slot is removed from the middle, the younger entries close the gap in the same cycle, so the stored order always matches program order. Four separate clear inputs (older-instruction exception, interrupt, mispredicted fetch, history-buffer recovery) each empty the whole queue. A clear overrides everything else that happens in its cycle.

The asynchronous reset input is released through a two-stage synchronizer.

Top module: `branch_fold_queue`

## Requirements
- R1: While reset is active, and after it, until the first word is accepted, `iss_valid` and `br_valid` are 0 and `enq_ready` is 1. Release of `rst_n` takes effect after two rising clock edges.
- R2: Lanes whose `enq_valid` bit is 1 are written behind all stored entries, lane 0 older than lane 1. They are accepted only when `enq_ready` is 1. `enq_ready` is 1 exactly when the free slots at the start of the cycle (4 minus the occupancy) are at least the number of set `enq_valid` bits.
- R3: An accepted word is visible on `iss_*` or `br_*` no earlier than the cycle after it is written.
- R4: `iss_valid` is 1 exactly when the queue is non-empty and its head entry has branch flag 0. `iss_instr` and `iss_addr` then show the head. The head is removed when `iss_valid` and `iss_ready` are both 1.
- R5: `br_valid` is 1 exactly when at least one stored entry has branch flag 1. `br_instr` and `br_addr` then show the oldest such entry. It is removed when `br_valid` and `br_ready` are both 1, and at most one branch leaves per cycle.
- R6: An issue and a fold may both complete in the same cycle, and together they remove two entries.
- R7: After any removal, the remaining entries keep their relative age order, and new words go behind them.
- R8: When any of `flush_exc`, `flush_irq`, `flush_mispredict` or `flush_recover` is 1 at a clock edge, the queue is empty in the next cycle. Words offered on the enqueue lanes in that cycle are dropped, and no issue or fold takes effect.
- R9: While `iss_valid` is 1 and `iss_ready` is 0, with no flush, the same head stays on `iss_instr`/`iss_addr` in the next cycle.
- R10: With 4 entries stored, `enq_ready` is 0 for any non-zero lane count. With 3 entries stored, it is 0 when both lanes are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 2 | Per-lane valid for fetched words |
| enq_instr | input | 2x32 | Fetched instruction words |
| enq_addr | input | 2x32 | Fetch addresses |
| enq_is_branch | input | 2 | Per-lane branch flag from predecode |
| enq_ready | output | 1 | Room for all valid lanes this cycle |
| iss_valid | output | 1 | Head is a non-branch word ready for dispatch |
| iss_ready | input | 1 | Execution side accepts the head |
| iss_instr | output | 32 | Head instruction |
| iss_addr | output | 32 | Head fetch address |
| br_valid | output | 1 | A branch is available for folding |
| br_ready | input | 1 | Branch side accepts the oldest branch |
| br_instr | output | 32 | Oldest stored branch instruction |
| br_addr | output | 32 | Oldest stored branch address |
| flush_exc | input | 1 | Clear: older instruction raised an exception |
| flush_irq | input | 1 | Clear: interrupt taken |
| flush_mispredict | input | 1 | Clear: fetch was mispredicted |
| flush_recover | input | 1 | Clear: history buffer recovery |

## Verification
The hardest cycle to reach combines several events. The queue must be nearly full, with a branch behind a non-branch head. Both the head issue and the middle fold must complete, while two new words arrive and possibly a clear lands on top. The stimulus reaches this cycle in phases. One phase throttles both ready inputs to pile up entries, another opens them to drain, and a third raises clear inputs often. Branch flags are set on about 40% of the words, so that branches often sit behind non-branch words.

// File: rtl/bfq_pkg.sv
package bfq_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned ADDR_W  = 32;

  typedef struct packed {
    logic [INSTR_W-1:0] instr;
    logic [ADDR_W-1:0]  addr;
    logic               is_br;
  } bfq_entry_t;
endpackage

// File: rtl/bfq_rst_sync.sv
module bfq_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/bfq_pick.sv
// Oldest-branch selector: lowest set bit of the candidate mask wins.
module bfq_pick #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] cand,
  output logic             found,
  output logic [DEPTH-1:0] sel_oh
);
  always_comb begin
    sel_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) sel_oh = DEPTH'(1) << i;
    end
  end

  assign found = |cand;

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh) && (found == (sel_oh != '0))); // R5
endmodule

// File: rtl/bfq_compact.sv
// Builds the next storage image: kept entries packed toward slot 0 in age
// order, then the accepted lanes appended behind them.
module bfq_compact import bfq_pkg::*; #(
  parameter  int unsigned DEPTH = 4,
  parameter  int unsigned ENQ_W = 2,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  bfq_entry_t       cur_ent [DEPTH],
  input  logic [DEPTH-1:0] keep,
  input  bfq_entry_t       lane_ent [ENQ_W],
  input  logic [ENQ_W-1:0] lane_vld,
  input  logic             take,
  output bfq_entry_t       nxt_ent [DEPTH],
  output logic [CW-1:0]    nxt_cnt
);
  logic [CW-1:0] pos;

  always_comb begin
    nxt_ent = cur_ent;
    pos     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        nxt_ent[pos] = cur_ent[i];
        pos          = pos + CW'(1);
      end
    end
    for (int j = 0; j < ENQ_W; j++) begin
      if (take && lane_vld[j] && (pos < CW'(DEPTH))) begin
        nxt_ent[pos] = lane_ent[j];
        pos          = pos + CW'(1);
      end
    end
    nxt_cnt = pos;
  end
endmodule

// File: rtl/branch_fold_queue.sv
module branch_fold_queue import bfq_pkg::*; #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ENQ_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENQ_W-1:0]              enq_valid,
  input  logic [ENQ_W-1:0][INSTR_W-1:0] enq_instr,
  input  logic [ENQ_W-1:0][ADDR_W-1:0]  enq_addr,
  input  logic [ENQ_W-1:0]              enq_is_branch,
  output logic                          enq_ready,
  output logic                          iss_valid,
  input  logic                          iss_ready,
  output logic [INSTR_W-1:0]            iss_instr,
  output logic [ADDR_W-1:0]             iss_addr,
  output logic                          br_valid,
  input  logic                          br_ready,
  output logic [INSTR_W-1:0]            br_instr,
  output logic [ADDR_W-1:0]             br_addr,
  input  logic                          flush_exc,
  input  logic                          flush_irq,
  input  logic                          flush_mispredict,
  input  logic                          flush_recover
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic             rst_sn;
  logic [CW-1:0]    cnt_q, cnt_n, cmp_cnt;
  bfq_entry_t       ent_q   [DEPTH];
  bfq_entry_t       cmp_ent [DEPTH];
  bfq_entry_t       lane_ent [ENQ_W];
  logic [DEPTH-1:0] occ, br_cand, br_oh, keep;
  logic             br_found, iss_fire, br_fire, flush_any, take, ent_we;
  logic [CW-1:0]    enq_n, free_slots;
  bfq_entry_t       br_sel;

  bfq_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sn)
  );

  // Slot state and removal mask
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign occ[i]     = CW'(i) < cnt_q;
    assign br_cand[i] = occ[i] & ent_q[i].is_br;
    assign keep[i]    = occ[i] & ~(iss_fire & (i == 0)) & ~(br_fire & br_oh[i]);
  end

  for (genvar j = 0; j < ENQ_W; j++) begin : g_lane
    assign lane_ent[j] = '{instr: enq_instr[j], addr: enq_addr[j], is_br: enq_is_branch[j]};
  end

  bfq_pick #(.DEPTH(DEPTH)) u_pick (
    .clk    (clk),
    .rst_n  (rst_sn),
    .cand   (br_cand),
    .found  (br_found),
    .sel_oh (br_oh)
  );

  always_comb begin
    br_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (br_oh[i]) br_sel = ent_q[i];
    end
  end

  // Port outputs
  assign flush_any  = flush_exc | flush_irq | flush_mispredict | flush_recover;
  assign iss_valid  = occ[0] & ~ent_q[0].is_br;
  assign iss_instr  = ent_q[0].instr;
  assign iss_addr   = ent_q[0].addr;
  assign br_valid   = br_found;
  assign br_instr   = br_sel.instr;
  assign br_addr    = br_sel.addr;
  assign iss_fire   = iss_valid & iss_ready & ~flush_any;
  assign br_fire    = br_valid & br_ready & ~flush_any;

  assign enq_n      = CW'($countones(enq_valid));
  assign free_slots = CW'(DEPTH) - cnt_q;
  assign enq_ready  = enq_n <= free_slots;
  assign take       = enq_ready & ~flush_any;

  bfq_compact #(.DEPTH(DEPTH), .ENQ_W(ENQ_W)) u_cmp (
    .cur_ent  (ent_q),
    .keep     (keep),
    .lane_ent (lane_ent),
    .lane_vld (enq_valid),
    .take     (take),
    .nxt_ent  (cmp_ent),
    .nxt_cnt  (cmp_cnt)
  );

  // Next state
  always_comb begin
    if (flush_any) begin
      cnt_n  = '0;
      ent_we = 1'b0;
    end else begin
      cnt_n  = cmp_cnt;
      ent_we = (|(occ & ~keep)) | (take & (|enq_valid));
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (ent_we) ent_q <= cmp_ent;
  end

  // Checks
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= CW'(DEPTH)); // R10

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_sn)
    flush_any |=> (!iss_valid && !br_valid && enq_ready)); // R8

  AST_OCC_TRACK: assert property (@(posedge clk) disable iff (!rst_sn)
    !flush_any |=> cnt_q == CW'($past(cnt_q) + ($past(enq_ready) ? $past(enq_n) : CW'(0))
                                - CW'($past(iss_fire)) - CW'($past(br_fire)))); // R2

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (iss_valid && !iss_ready && !flush_any) |=>
      (iss_valid && iss_instr == $past(iss_instr) && iss_addr == $past(iss_addr))); // R9
endmodule

// File: tb/branch_fold_queue_test.sv
`timescale 1ns/1ps
module branch_fold_queue_test;
  localparam int DEPTH = 4;
  localparam int EW    = 2;

  typedef struct {
    logic [31:0] ins;
    logic [31:0] pc;
    bit          br;
  } ment_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [EW-1:0]        enq_valid;
  logic [EW-1:0][31:0]  enq_instr;
  logic [EW-1:0][31:0]  enq_addr;
  logic [EW-1:0]        enq_is_branch;
  logic                 enq_ready, iss_valid, iss_ready, br_valid, br_ready;
  logic [31:0]          iss_instr, iss_addr, br_instr, br_addr;
  logic                 flush_exc, flush_irq, flush_mispredict, flush_recover;

  ment_t mq[$];
  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;

  always #2 clk = ~clk;

  branch_fold_queue uut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_instr(enq_instr), .enq_addr(enq_addr),
    .enq_is_branch(enq_is_branch), .enq_ready(enq_ready),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_instr(iss_instr), .iss_addr(iss_addr),
    .br_valid(br_valid), .br_ready(br_ready), .br_instr(br_instr), .br_addr(br_addr),
    .flush_exc(flush_exc), .flush_irq(flush_irq),
    .flush_mispredict(flush_mispredict), .flush_recover(flush_recover)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : main
    string ctx;
    rst_n = 1'b0;
    enq_valid = '0; enq_instr = '0; enq_addr = '0; enq_is_branch = '0;
    iss_ready = 1'b0; br_ready = 1'b0;
    flush_exc = 1'b0; flush_irq = 1'b0; flush_mispredict = 1'b0; flush_recover = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state while reset is held
    chk(iss_valid == 1'b0, "R1", "iss_valid in reset", 64'(iss_valid), 0);
    chk(br_valid == 1'b0,  "R1", "br_valid in reset",  64'(br_valid), 0);
    chk(enq_ready == 1'b1, "R1", "enq_ready in reset", 64'(enq_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(iss_valid == 1'b0 && br_valid == 1'b0, "R1", "outputs after release",
        64'({iss_valid, br_valid}), 0);
    ctx = "";

    for (int c = 0; c < 6000; c++) begin
      int regime, bi, nen, pre_size;
      bit exp_iv, exp_bv, exp_er, fl, ifire, bfire;
      string tag;
      @(negedge clk);
      regime = (c / 300) % 4;
      for (int j = 0; j < EW; j++) begin
        enq_valid[j]     = ($urandom_range(0, 99) < 65);
        enq_instr[j]     = $urandom;
        enq_addr[j]      = $urandom;
        enq_is_branch[j] = ($urandom_range(0, 99) < 40);
      end
      case (regime)
        1:       begin iss_ready = ($urandom_range(0, 9) < 2); br_ready = ($urandom_range(0, 9) < 2); end
        2:       begin iss_ready = ($urandom_range(0, 9) < 9); br_ready = ($urandom_range(0, 9) < 9); end
        default: begin iss_ready = $urandom_range(0, 1);       br_ready = $urandom_range(0, 1); end
      endcase
      flush_exc = 1'b0; flush_irq = 1'b0; flush_mispredict = 1'b0; flush_recover = 1'b0;
      if ($urandom_range(0, 99) < ((regime == 3) ? 12 : 1)) begin
        case ($urandom_range(0, 3))
          0: flush_exc = 1'b1;
          1: flush_irq = 1'b1;
          2: flush_mispredict = 1'b1;
          default: flush_recover = 1'b1;
        endcase
      end
      #1;
      // expected values from the behavioural queue
      bi = -1;
      foreach (mq[k]) if (mq[k].br && bi < 0) bi = k;
      nen = $countones(enq_valid);
      exp_iv = (mq.size() > 0) && !mq[0].br;
      exp_bv = (bi >= 0);
      exp_er = (DEPTH - mq.size()) >= nen;
      tag = (ctx != "") ? ctx : "R4";
      chk(iss_valid == exp_iv, tag, "iss_valid", 64'(iss_valid), 64'(exp_iv));
      if (exp_iv) begin
        chk(iss_instr == mq[0].ins && iss_addr == mq[0].pc, (ctx != "") ? ctx : "R7",
            "head word", {iss_instr, iss_addr}, {mq[0].ins, mq[0].pc});
      end
      chk(br_valid == exp_bv, (ctx != "") ? ctx : "R5", "br_valid", 64'(br_valid), 64'(exp_bv));
      if (exp_bv) begin
        chk(br_instr == mq[bi].ins && br_addr == mq[bi].pc, "R5", "oldest branch",
            {br_instr, br_addr}, {mq[bi].ins, mq[bi].pc});
      end
      chk(enq_ready == exp_er, (mq.size() >= DEPTH - 1) ? "R10" : "R2", "enq_ready",
          64'(enq_ready), 64'(exp_er));

      // model update for the coming edge
      fl = flush_exc | flush_irq | flush_mispredict | flush_recover;
      pre_size = mq.size();
      ifire = exp_iv && iss_ready;
      bfire = exp_bv && br_ready;
      ctx = "";
      if (fl) begin
        mq.delete();          // R8: all clear inputs empty the queue
        ctx = "R8";
      end else begin
        // R6: fold and issue in one cycle; branch index is above 0 then
        if (bfire) mq.delete(bi);
        if (ifire) mq.delete(0);
        if (ifire && bfire) ctx = "R6";
        if (!ifire && exp_iv && ctx == "") ctx = "R9";
        if (exp_er) begin
          for (int j = 0; j < EW; j++) begin
            if (enq_valid[j]) mq.push_back('{ins: enq_instr[j], pc: enq_addr[j], br: enq_is_branch[j]});
          end
          // R3: words written into an empty queue appear only next cycle
          if (pre_size == 0 && nen > 0 && ctx == "") ctx = "R3";
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule